// File: doc/BRIEF.md
# Streaming AND-CFAR Threshold Detector

This block decides, for every magnitude sample of a radar spectrum, whether the cell is a target. Samples arrive one per clock with a valid strobe. The block keeps a sliding window around the cell under test (CUT). The window has a leading half and a lagging half of reference cells. Guard cells on each side of the CUT are left out of both halves.

Two noise estimates are formed from the same reference cells. The first is a running sum for the cell-averaging estimate. It is updated each step with four add/subtract terms: one sample enters and one leaves each half. The second is the k-th smallest reference value for the order-statistics estimate. It comes from a list kept in ascending order. Each half's transition is applied as one removal and one insertion, so no full sort is ever run.

The CUT is declared a target only when it beats both scaled estimates. The order index and the 4.4 fixed-point scale factor can be changed at run time. A frame-start marker restarts the window for each new spectrum.

Top module: `and_cfar_detector`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `det_valid` and `det_flag` are 0 and `det_index` is 0.
- R2: The cell-averaging sum covers exactly 2*HALF reference cells. These are the HALF cells newer than the CUT and the HALF cells older than it, skipping GUARD cells on each side of the CUT. The CUT itself is never included.
- R3: The order-statistics estimate is the sorted reference set indexed by `k_sel`, with 0 the smallest value and 2*HALF-1 the largest. Equal values count as separate entries.
- R4: The cell-averaging test passes when cut*16*2*HALF > T*sum, where T is `t_scale` read as unsigned 4.4 fixed point. The comparison is strict.
- R5: The order-statistics test passes when cut*16 > T*x(k). The comparison is strict.
- R6: `det_flag` is 1 only when both the R4 and R5 tests pass, and it is 0 whenever `det_valid` is 0.
- R7: Each accepted sample (`in_valid`=1) that leaves the window full produces exactly one decision, with `det_valid` high on the second rising edge after the sample. Cycles with `in_valid`=0 produce no decision.
- R8: No decision is issued until 2*HALF+2*GUARD+1 samples of the current frame have been accepted.
- R9: A sample accepted with `frame_start`=1 clears the window and becomes index 0 of a new frame. `frame_start` has no effect while `in_valid` is 0.
- R10: `det_index` is the in-frame index of the CUT, which is the newest index minus HALF+GUARD, modulo 2^IDXW.
- R11: `k_sel` and `t_scale` are taken together with the sample that completes a decision's window. A change applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| frame_start | input | 1 | Marks the first sample of a spectrum frame |
| in_sample | input | DW | Unsigned magnitude sample |
| k_sel | input | $clog2(2*HALF) | Order index into the sorted reference set |
| t_scale | input | TW | Scale factor, unsigned 4.4 fixed point |
| det_valid | output | 1 | A decision is present |
| det_flag | output | 1 | The CUT is a target |
| det_index | output | IDXW | In-frame index of the CUT |

## Verification
The bench builds the block with its default parameters: 8-bit samples, four reference cells per half, one guard cell per side, an 8-bit scale factor and an 8-bit index. This makes an 11-cell window, which is short enough that frames shorter than the window, frame restarts before the window fills, and every order index from the minimum to the maximum can each be reached in a few dozen samples. With 8-bit samples and scale, the extremes of the products (all 255 with T=0xFF, all zero with T=0) are within reach. Small noise values also give the many equal entries that exercise the first-match removal in the sorted list.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

    // Number of fraction bits of the scale factor (4.4 fixed point).
    localparam int unsigned T_FRAC = 4;

    // Outcome of the two individual threshold tests.
    typedef struct packed {
        logic ca_hit;
        logic os_hit;
    } cfar_hits_t;

    // Total span of the sliding window: both halves, both guards, the CUT.
    function automatic int unsigned span_len(int unsigned half, int unsigned guard);
        return 2 * half + 2 * guard + 1;
    endfunction

endpackage

// File: rtl/cfar_sort_step.sv
// One removal and one insertion on an ascending list, purely combinational.
module cfar_sort_step #(
    parameter int unsigned DW = 8,
    parameter int unsigned N  = 8
) (
    input  logic [N-1:0][DW-1:0] list_in,
    input  logic [DW-1:0]        rem_val,
    input  logic [DW-1:0]        ins_val,
    output logic [N-1:0][DW-1:0] list_out,
    output logic                 rem_hit
);
    logic [N-1:0]          match;
    logic [N-1:0]          seen;
    logic [N-2:0][DW-1:0]  gap;
    logic [N-2:0]          above;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            match[i] = (list_in[i] == rem_val);
        end
        seen[0] = match[0];
        for (int i = 1; i < N; i++) begin
            seen[i] = seen[i-1] | match[i];
        end
    end

    // Close the gap left by the first matching entry, then mark entries above the newcomer.
    for (genvar i = 0; i < N - 1; i++) begin : g_close
        assign gap[i]   = seen[i] ? list_in[i+1] : list_in[i];
        assign above[i] = gap[i] > ins_val;
    end

    // Open a slot in front of the first larger entry.
    assign list_out[0] = above[0] ? ins_val : gap[0];
    for (genvar i = 1; i < N - 1; i++) begin : g_open
        assign list_out[i] = above[i-1] ? gap[i-1] : (above[i] ? ins_val : gap[i]);
    end
    assign list_out[N-1] = above[N-2] ? gap[N-2] : ins_val;

    assign rem_hit = seen[N-1];

endmodule

// File: rtl/cfar_window.sv
// Sliding sample window with incremental reference sum and sorted reference list.
module cfar_window #(
    parameter int unsigned DW    = 8,
    parameter int unsigned HALF  = 4,
    parameter int unsigned GUARD = 1,
    parameter int unsigned IDXW  = 8,
    localparam int unsigned L    = cfar_pkg::span_len(HALF, GUARD),
    localparam int unsigned N    = 2 * HALF,
    localparam int unsigned SW   = DW + $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 frame_start,
    input  logic [DW-1:0]        in_sample,
    output logic [DW-1:0]        cut,
    output logic [SW-1:0]        ref_sum,
    output logic [N-1:0][DW-1:0] ref_sorted,
    output logic [IDXW-1:0]      newest_idx,
    output logic                 full,
    output logic                 step
);
    localparam int unsigned FW      = $clog2(L + 1);
    localparam int unsigned CUT_POS = HALF + GUARD;
    localparam int unsigned LAG_IN  = HALF + 2 * GUARD;

    logic [L-1:0][DW-1:0] win, base_win;
    logic [N-1:0][DW-1:0] base_sorted, mid_sorted, nxt_sorted;
    logic [SW-1:0]        base_sum, nxt_sum;
    logic [FW-1:0]        fill, base_fill;
    logic                 lead_hit, lag_hit;

    // A frame start rebuilds from an empty (all-zero) window.
    always_comb begin
        base_win    = frame_start ? '0 : win;
        base_sorted = frame_start ? '0 : ref_sorted;
        base_sum    = frame_start ? '0 : ref_sum;
        base_fill   = frame_start ? '0 : fill;
        nxt_sum     = base_sum + SW'(in_sample) - SW'(base_win[HALF-1])
                    + SW'(base_win[LAG_IN]) - SW'(base_win[L-1]);
    end

    cfar_sort_step #(.DW(DW), .N(N)) u_lead (
        .list_in  (base_sorted),
        .rem_val  (base_win[HALF-1]),
        .ins_val  (in_sample),
        .list_out (mid_sorted),
        .rem_hit  (lead_hit)
    );

    cfar_sort_step #(.DW(DW), .N(N)) u_lag (
        .list_in  (mid_sorted),
        .rem_val  (base_win[L-1]),
        .ins_val  (base_win[LAG_IN]),
        .list_out (nxt_sorted),
        .rem_hit  (lag_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win        <= '0;
            ref_sorted <= '0;
            ref_sum    <= '0;
            fill       <= '0;
            newest_idx <= '0;
            step       <= 1'b0;
        end else begin
            step <= in_valid;
            if (in_valid) begin
                win        <= {base_win[L-2:0], in_sample};
                ref_sorted <= nxt_sorted;
                ref_sum    <= nxt_sum;
                fill       <= (base_fill == FW'(L)) ? base_fill : base_fill + 1'b1;
                newest_idx <= frame_start ? '0 : newest_idx + 1'b1;
            end
        end
    end

    assign cut  = win[CUT_POS];
    assign full = (fill == FW'(L));

    // Direct recomputation of the reference sum, for checking only.
    function automatic logic [SW-1:0] direct_total(logic [L-1:0][DW-1:0] w);
        logic [SW-1:0] acc = '0;
        for (int i = 0; i < L; i++) begin
            if (i < HALF || i > LAG_IN) acc = acc + SW'(w[i]);
        end
        return acc;
    endfunction

    assert_ca_sum_R2: assert property (@(posedge clk) disable iff (rst)
        ref_sum == direct_total(win));

    assert_removal_found_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (lead_hit && lag_hit));

    for (genvar i = 0; i < N - 1; i++) begin : g_order_chk
        assert_sorted_R3: assert property (@(posedge clk) disable iff (rst)
            ref_sorted[i] <= ref_sorted[i+1]);
    end

endmodule

// File: rtl/cfar_decide.sv
// Division-free comparison of the CUT against both scaled estimates.
module cfar_decide #(
    parameter int unsigned DW = 8,
    parameter int unsigned N  = 8,
    parameter int unsigned TW = 8,
    localparam int unsigned SW = DW + $clog2(N),
    localparam int unsigned CW = TW + SW + cfar_pkg::T_FRAC,
    localparam int unsigned OW = TW + DW + cfar_pkg::T_FRAC
) (
    input  logic [DW-1:0]       cut,
    input  logic [SW-1:0]       ref_sum,
    input  logic [DW-1:0]       order_val,
    input  logic [TW-1:0]       t_scale,
    output cfar_pkg::cfar_hits_t hits
);
    logic [CW-1:0] ca_lhs, ca_rhs;
    logic [OW-1:0] os_lhs, os_rhs;

    always_comb begin
        ca_lhs      = CW'(cut) * CW'(N * (2 ** cfar_pkg::T_FRAC));
        ca_rhs      = CW'(t_scale) * CW'(ref_sum);
        os_lhs      = OW'(cut) << cfar_pkg::T_FRAC;
        os_rhs      = OW'(t_scale) * OW'(order_val);
        hits.ca_hit = ca_lhs > ca_rhs;
        hits.os_hit = os_lhs > os_rhs;
    end

endmodule

// File: rtl/and_cfar_detector.sv
module and_cfar_detector #(
    parameter int unsigned DW    = 8,
    parameter int unsigned HALF  = 4,
    parameter int unsigned GUARD = 1,
    parameter int unsigned TW    = 8,
    parameter int unsigned IDXW  = 8,
    localparam int unsigned N    = 2 * HALF,
    localparam int unsigned KW   = $clog2(N),
    localparam int unsigned SW   = DW + $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            frame_start,
    input  logic [DW-1:0]   in_sample,
    input  logic [KW-1:0]   k_sel,
    input  logic [TW-1:0]   t_scale,
    output logic            det_valid,
    output logic            det_flag,
    output logic [IDXW-1:0] det_index
);
    logic [DW-1:0]        cut;
    logic [SW-1:0]        ref_sum;
    logic [N-1:0][DW-1:0] ref_sorted;
    logic [IDXW-1:0]      newest_idx;
    logic                 full, step;
    logic [KW-1:0]        k_q;
    logic [TW-1:0]        t_q;
    cfar_pkg::cfar_hits_t hits;

    cfar_window #(.DW(DW), .HALF(HALF), .GUARD(GUARD), .IDXW(IDXW)) u_win (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .frame_start (frame_start),
        .in_sample   (in_sample),
        .cut         (cut),
        .ref_sum     (ref_sum),
        .ref_sorted  (ref_sorted),
        .newest_idx  (newest_idx),
        .full        (full),
        .step        (step)
    );

    cfar_decide #(.DW(DW), .N(N), .TW(TW)) u_decide (
        .cut       (cut),
        .ref_sum   (ref_sum),
        .order_val (ref_sorted[k_q]),
        .t_scale   (t_q),
        .hits      (hits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q       <= '0;
            t_q       <= '0;
            det_valid <= 1'b0;
            det_flag  <= 1'b0;
            det_index <= '0;
        end else begin
            if (in_valid) begin
                k_q <= k_sel;
                t_q <= t_scale;
            end
            det_valid <= step && full;
            det_flag  <= step && full && hits.ca_hit && hits.os_hit;
            if (step && full) begin
                det_index <= newest_idx - IDXW'(HALF + GUARD);
            end
        end
    end

    assert_flag_gated_R6: assert property (@(posedge clk) disable iff (rst)
        !det_valid |-> !det_flag);

    assert_fill_gate_R8: assert property (@(posedge clk) disable iff (rst)
        det_valid |-> $past(full));

    assert_one_per_sample_R7: assert property (@(posedge clk) disable iff (rst)
        det_valid |-> $past(in_valid, 2));

endmodule

// File: tb/tb_and_cfar_detector.sv
`timescale 1ns/1ps
module tb_and_cfar_detector;
    localparam int DW = 8, HALF = 4, GUARD = 1, TW = 8, IDXW = 8;
    localparam int N = 2 * HALF, L = 2 * HALF + 2 * GUARD + 1, KW = $clog2(N);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst, in_valid, frame_start;
    logic [DW-1:0]   in_sample;
    logic [KW-1:0]   k_sel;
    logic [TW-1:0]   t_scale;
    logic            det_valid, det_flag;
    logic [IDXW-1:0] det_index;

    and_cfar_detector #(.DW(DW), .HALF(HALF), .GUARD(GUARD), .TW(TW), .IDXW(IDXW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
        .in_sample(in_sample), .k_sel(k_sel), .t_scale(t_scale),
        .det_valid(det_valid), .det_flag(det_flag), .det_index(det_index)
    );

    int errors = 0, checks = 0;
    int win [L];
    int fill = 0, newest = 0;
    bit pv [2];
    bit pf [2];
    int pi [2];
    string pt [2];
    string scen = "R1_reset";

    task automatic fail_line(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
    endtask

    task automatic step(input bit v, input int s, input bit fs, input int k, input int t);
        int q[$];
        int sum, cut, xk;
        bit ca, os;
        @(negedge clk);
        checks++;
        if (det_valid !== pv[1]) fail_line("R7/R8 valid", det_valid, pv[1]);
        if (pv[1]) begin
            checks++;
            if (det_flag !== pf[1]) fail_line(pt[1], det_flag, pf[1]);
            checks++;
            if (det_index !== pi[1][IDXW-1:0]) fail_line("R10 index", det_index, pi[1]);
        end else begin
            checks++;
            if (det_flag !== 1'b0) fail_line("R6 idle flag", det_flag, 0);
        end
        pv[1] = pv[0]; pf[1] = pf[0]; pi[1] = pi[0]; pt[1] = pt[0];
        pv[0] = 0; pf[0] = 0; pi[0] = 0; pt[0] = "";
        if (v) begin
            if (fs) begin
                foreach (win[i]) win[i] = 0;
                fill = 0;
                newest = 0;
            end else begin
                newest++;
            end
            for (int i = L - 1; i > 0; i--) win[i] = win[i-1];
            win[0] = s;
            if (fill < L) fill++;
            if (fill == L) begin
                cut = win[HALF + GUARD];
                sum = 0;
                for (int i = 0; i < L; i++) begin
                    if (i < HALF || i > HALF + 2 * GUARD) begin
                        sum += win[i];
                        q.push_back(win[i]);
                    end
                end
                q.sort();
                xk = q[k];
                ca = (cut * 16 * N) > (t * sum);
                os = (cut * 16) > (t * xk);
                pv[0] = 1;
                pf[0] = ca && os;
                pi[0] = (newest - HALF - GUARD) & ((1 << IDXW) - 1);
                pt[0] = ca ? (os ? "R6 both" : "R5 os-test") : (os ? "R4 ca-test" : "R4 R5 neither");
            end
        end
        in_valid = v; in_sample = DW'(s); frame_start = fs;
        k_sel = KW'(k); t_scale = TW'(t);
    endtask

    task automatic noise_frame(input int len, input int k, input int t, input int vpct);
        for (int i = 0; i < len; i++) begin
            int s;
            s = ($urandom_range(99, 0) < 8) ? $urandom_range(255, 120) : $urandom_range(15, 1);
            if (i != 0) begin
                while ($urandom_range(99, 0) >= vpct) step(0, 0, 0, k, t);
            end
            step(1, s, i == 0, k, t);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(7));
        rst = 1; in_valid = 0; frame_start = 0; in_sample = 0; k_sel = 0; t_scale = 0;
        foreach (win[i]) win[i] = 0;
        pv[0] = 0; pv[1] = 0; pf[0] = 0; pf[1] = 0; pi[0] = 0; pi[1] = 0;
        repeat (3) step(0, 0, 0, 0, 0);
        @(negedge clk); rst = 0;
        // R1: reset state observed after release
        checks++;
        if (det_valid !== 0 || det_flag !== 0) fail_line("R1 outputs", {det_valid, det_flag}, 0);
        checks++;
        if (det_index !== 0) fail_line("R1 index", det_index, 0);

        scen = "R2_ca_window";      noise_frame(60, 5, 8'h18, 100);
        scen = "R3_k_min";          noise_frame(40, 0, 8'h20, 100);
        scen = "R3_k_max";          noise_frame(40, N - 1, 8'h12, 100);
        scen = "R4_R5_mixed_T";     noise_frame(50, 3, 8'h30, 100);
        scen = "R7_valid_gaps";     noise_frame(60, 4, 8'h14, 60);

        scen = "R3_ties";
        for (int i = 0; i < 30; i++) step(1, (i % 3 == 0) ? 7 : 5, i == 0, 2, 8'h10);

        scen = "R8_short_frames";
        for (int f = 0; f < 3; f++)
            for (int i = 0; i < L - 1; i++) step(1, 200, i == 0, 0, 8'h01);

        scen = "R9_frame_restart";
        noise_frame(25, 6, 8'h16, 100);
        step(0, 0, 1, 6, 8'h16);   // frame_start without valid: no effect
        for (int i = 0; i < 15; i++) step(1, $urandom_range(15, 1), 0, 6, 8'h16);
        noise_frame(30, 1, 8'h1c, 100);

        scen = "R11_runtime_change";
        for (int i = 0; i < 60; i++)
            step(1, $urandom_range(40, 1), i == 0, $urandom_range(N - 1, 0), $urandom_range(48, 8));

        scen = "R4_R5_max_values";
        for (int i = 0; i < 20; i++) step(1, 255, i == 0, N - 1, 8'hff);
        for (int i = 0; i < 20; i++) step(1, (i == 12) ? 255 : 254, i == 0, N - 1, 8'h10);
        scen = "R4_R5_zero";
        for (int i = 0; i < 20; i++) step(1, (i == 14) ? 1 : 0, i == 0, 0, 8'h00);

        scen = "R10_long_frame";    noise_frame(300, 2, 8'h20, 100);

        repeat (3) step(0, 0, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule